// File: doc/BRIEF.md
# Power-Down Clock Output Sequencer

This block sits between a clock synthesizer's output dividers and its pad drivers. It stops a set of generated clocks cleanly when a power-down pin is raised, and brings them back when the pin is dropped. Every single-ended clock is stopped low, and only on its own falling edge, so no shortened pulse reaches a pin. Every differential pair is parked on a falling edge of its complement phase. A per-pair mode bit chooses the parked state: either the true leg is driven high while the complement floats, or both legs float.

The power-down pin is synchronized into the domain of the CPU complement reference clock and must be seen high on two consecutive qualified samples before entry begins. The mode bits are captured at that moment. A VCO-off request is raised only after every output reports parked, and an oscillator-off request follows one reference cycle later. Dropping the pin clears both requests at once, with no clock needed, and turns any floating true leg back to driven-high. Full clocking resumes once the PLL reports lock, with each output restarting on its own edge.

Top module: `pwrdn_clk_seq`

## Requirements
- R1: Power-down entry starts only when the pin, after a two-flop synchronizer clocked by rising edges of `ref_c_i`, is high on two consecutive samples. A pulse shorter than three reference periods is ignored, and the outputs keep toggling.
- R2: Each single-ended output is forced low from its own next falling edge after entry begins. No high pulse on any single-ended output is ever shorter than half that clock's period.
- R3: Each differential pair parks on a falling edge of its complement input. With the captured mode bit at 0, the parked pair has `dt_o`=1, `dt_oe_o`=1 and `dc_oe_o`=0.
- R4: With the captured mode bit at 1, the parked pair has `dt_oe_o`=0 and `dc_oe_o`=0.
- R5: The mode bits (bit i selects pair i) are captured when entry begins. Changes on `drv_mode_i` while power-down is in effect do not change any output. The next entry uses the new values.
- R6: `vco_off_o` rises only when every single-ended output is low and every complement enable is 0. `osc_off_o` rises one reference cycle later. `pd_done_o` is 1 while the oscillator-off state is held.
- R7: Dropping `pd_i` clears `vco_off_o` and `osc_off_o` at once, with no clock edge needed. Any pair whose true leg was floating then drives `dt_o`=1 with `dt_oe_o`=1, while `dc_oe_o` stays 0.
- R8: After `pd_i` drops, the outputs stay parked until `lock_i` is seen high. They then resume toggling, with each single-ended output passing its input clock again.
- R9: During and after reset with `pd_i` low, every output follows its input clock, every enable is 1, and `vco_off_o`, `osc_off_o` and `pd_done_o` are 0.
- R10: While `pd_done_o` is 1, no clock output or output enable changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_c_i | input | 1 | CPU complement reference clock; sequencing domain |
| pd_i | input | 1 | Power-down request pin |
| lock_i | input | 1 | PLL lock indication |
| drv_mode_i | input | N_DIFF | Parked-state select per pair (0: true high, 1: both float) |
| se_clk_i | input | N_SE | Single-ended clocks from the dividers |
| dt_i | input | N_DIFF | Differential true-phase clocks |
| dc_i | input | N_DIFF | Differential complement-phase clocks |
| se_clk_o | output | N_SE | Gated single-ended clocks |
| dt_o | output | N_DIFF | Gated true-leg values |
| dt_oe_o | output | N_DIFF | True-leg output enables |
| dc_o | output | N_DIFF | Gated complement-leg values |
| dc_oe_o | output | N_DIFF | Complement-leg output enables |
| vco_off_o | output | 1 | VCO shutdown request |
| osc_off_o | output | 1 | Crystal oscillator shutdown request |
| pd_done_o | output | 1 | Power-down sequence complete |

## Verification
A pin pulse that spans only one or two reference edges is applied. A design without the two-sample qualification would start parking on it. Every high pulse on the single-ended outputs is timed. A gate that switched on the rising edge, or that used a plain AND with the request, would produce a short pulse. The bench flips the mode bits while the block is powered down and then re-enters with swapped modes. A design that read the mode bits live would change the enables while parked. The bench drops the pin with lock held low and samples at once. A design that waited for a clock to clear the shutdown requests, or that released outputs before lock, would show the wrong enables or toggling outputs.

// File: rtl/pds_pkg.sv
`timescale 1ns/1ps
package pds_pkg;
   typedef enum logic [2:0] {
      ST_RUN  = 3'd0,
      ST_STOP = 3'd1,
      ST_VCO  = 3'd2,
      ST_OSC  = 3'd3,
      ST_WAKE = 3'd4
   } pds_state_e;
endpackage

// File: rtl/pds_sync.sv
`timescale 1ns/1ps
module pds_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk_i,
   input  logic             clr_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pds_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("pds_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] sr_q;

   always_ff @(posedge clk_i or negedge clr_ni) begin
      if (!clr_ni) sr_q <= '0;
      else         sr_q <= {sr_q[STAGES-2:0], d_i};
   end

   assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/pds_se_gate.sv
`timescale 1ns/1ps
module pds_se_gate (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic stop_i,
   output logic clk_o,
   output logic parked_o
);
   logic stop_q;

   // Request is taken only while the clock is falling, so the output is low
   // whenever the gate changes state.
   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stop_q <= 1'b0;
      else         stop_q <= stop_i;
   end

   assign clk_o    = clk_i & ~stop_q;
   assign parked_o = stop_q;
endmodule

// File: rtl/pds_diff_gate.sv
`timescale 1ns/1ps
module pds_diff_gate (
   input  logic dt_i,
   input  logic dc_i,
   input  logic rst_ni,
   input  logic stop_i,
   input  logic mode_i,
   input  logic pd_pin_i,
   output logic dt_o,
   output logic dt_oe_o,
   output logic dc_o,
   output logic dc_oe_o,
   output logic parked_o
);
   logic park_q;

   // Complement falling edge equals true rising edge: holding true high
   // from that edge does not clip a pulse.
   always_ff @(negedge dc_i or negedge rst_ni) begin
      if (!rst_ni) park_q <= 1'b0;
      else         park_q <= stop_i;
   end

   assign dt_o     = park_q | dt_i;
   // Floating true leg is re-driven as soon as the pin drops.
   assign dt_oe_o  = ~park_q | ~mode_i | ~pd_pin_i;
   assign dc_o     = dc_i & ~park_q;
   assign dc_oe_o  = ~park_q;
   assign parked_o = park_q;
endmodule

// File: rtl/pds_ctrl.sv
`timescale 1ns/1ps
module pds_ctrl
   import pds_pkg::*;
#(
   parameter int N_DIFF      = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              pd_i,
   input  logic              lock_i,
   input  logic              parked_all_i,
   input  logic [N_DIFF-1:0] mode_i,
   output logic              stop_o,
   output logic [N_DIFF-1:0] mode_o,
   output logic              vco_off_o,
   output logic              osc_off_o,
   output logic              done_o
);
   logic       pd_clr_n;
   logic       pd_s, pd_prev_q, pd_ok;
   logic       lock_s, parked_s;
   pds_state_e st, st_nx;
   logic [N_DIFF-1:0] mode_q;

   // Pin low clears the request path at once.
   assign pd_clr_n = rst_ni & pd_i;

   pds_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_pd_sync (
      .clk_i (clk_i), .clr_ni(pd_clr_n), .d_i(1'b1), .q_o(pd_s)
   );

   always_ff @(posedge clk_i or negedge pd_clr_n) begin
      if (!pd_clr_n) pd_prev_q <= 1'b0;
      else           pd_prev_q <= pd_s;
   end

   assign pd_ok = pd_s & pd_prev_q;

   pds_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_stat_sync (
      .clk_i (clk_i), .clr_ni(rst_ni),
      .d_i   ({lock_i, parked_all_i}),
      .q_o   ({lock_s, parked_s})
   );

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_RUN:  if (pd_ok)    st_nx = ST_STOP;
         ST_STOP: if (parked_s) st_nx = ST_VCO;
         ST_VCO:  st_nx = pd_s ? ST_OSC : ST_WAKE;
         ST_OSC:  if (!pd_s)    st_nx = ST_WAKE;
         ST_WAKE: if (lock_s)   st_nx = ST_RUN;
         default: st_nx = ST_RUN;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st     <= ST_RUN;
         mode_q <= '0;
      end else begin
         st <= st_nx;
         if (st == ST_RUN && st_nx == ST_STOP) mode_q <= mode_i;
      end
   end

   assign stop_o    = (st != ST_RUN);
   assign mode_o    = mode_q;
   assign vco_off_o = ((st == ST_VCO) || (st == ST_OSC)) & pd_i;
   assign osc_off_o = (st == ST_OSC) & pd_i;
   assign done_o    = (st == ST_OSC);

   p_entry_qualified_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(st) == ST_RUN && st == ST_STOP) |-> ($past(pd_s) && $past(pd_prev_q)));

   p_mode_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st != ST_RUN && $past(st) != ST_RUN) |-> $stable(mode_q));

   p_shutdown_after_park_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st == ST_VCO || st == ST_OSC) |-> parked_all_i);

   p_osc_after_vco_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st == ST_OSC && $past(st) != ST_OSC) |-> ($past(st) == ST_VCO));

   p_resume_needs_lock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(st) == ST_WAKE && st == ST_RUN) |-> $past(lock_s));
endmodule

// File: rtl/pwrdn_clk_seq.sv
`timescale 1ns/1ps
module pwrdn_clk_seq #(
   parameter int N_SE        = 2,
   parameter int N_DIFF      = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              rst_ni,
   input  logic              ref_c_i,
   input  logic              pd_i,
   input  logic              lock_i,
   input  logic [N_DIFF-1:0] drv_mode_i,
   input  logic [N_SE-1:0]   se_clk_i,
   input  logic [N_DIFF-1:0] dt_i,
   input  logic [N_DIFF-1:0] dc_i,
   output logic [N_SE-1:0]   se_clk_o,
   output logic [N_DIFF-1:0] dt_o,
   output logic [N_DIFF-1:0] dt_oe_o,
   output logic [N_DIFF-1:0] dc_o,
   output logic [N_DIFF-1:0] dc_oe_o,
   output logic              vco_off_o,
   output logic              osc_off_o,
   output logic              pd_done_o
);
   localparam int N_OUT = N_SE + N_DIFF;

   generate
      if (N_SE < 1)        begin : g_bad_se   $error("pwrdn_clk_seq: N_SE must be at least 1");   end
      if (N_DIFF < 1)      begin : g_bad_diff $error("pwrdn_clk_seq: N_DIFF must be at least 1"); end
      if (SYNC_STAGES < 2) begin : g_bad_sync $error("pwrdn_clk_seq: SYNC_STAGES must be at least 2"); end
   endgenerate

   logic              stop;
   logic [N_DIFF-1:0] mode_hold;
   logic [N_OUT-1:0]  parked;
   logic              parked_all;

   for (genvar i = 0; i < N_SE; i++) begin : g_se
      pds_se_gate u_gate (
         .clk_i   (se_clk_i[i]),
         .rst_ni  (rst_ni),
         .stop_i  (stop),
         .clk_o   (se_clk_o[i]),
         .parked_o(parked[i])
      );
   end

   for (genvar j = 0; j < N_DIFF; j++) begin : g_diff
      pds_diff_gate u_gate (
         .dt_i    (dt_i[j]),
         .dc_i    (dc_i[j]),
         .rst_ni  (rst_ni),
         .stop_i  (stop),
         .mode_i  (mode_hold[j]),
         .pd_pin_i(pd_i),
         .dt_o    (dt_o[j]),
         .dt_oe_o (dt_oe_o[j]),
         .dc_o    (dc_o[j]),
         .dc_oe_o (dc_oe_o[j]),
         .parked_o(parked[N_SE+j])
      );
   end

   assign parked_all = &parked;

   pds_ctrl #(.N_DIFF(N_DIFF), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
      .clk_i       (ref_c_i),
      .rst_ni      (rst_ni),
      .pd_i        (pd_i),
      .lock_i      (lock_i),
      .parked_all_i(parked_all),
      .mode_i      (drv_mode_i),
      .stop_o      (stop),
      .mode_o      (mode_hold),
      .vco_off_o   (vco_off_o),
      .osc_off_o   (osc_off_o),
      .done_o      (pd_done_o)
   );
endmodule

// File: tb/pwrdn_clk_seq_tb.sv
`timescale 1ns/1ps
module pwrdn_clk_seq_tb;
   logic       rst_n = 1'b0, ref_c = 1'b0, pd = 1'b0, lock = 1'b1;
   logic [1:0] mode = 2'b00;
   logic [1:0] se_in = 2'b00;
   logic       d1 = 1'b0;
   logic [1:0] dt_in, dc_in;
   logic [1:0] se_o, dt_o, dt_oe, dc_o, dc_oe;
   logic       vco_off, osc_off, done;
   int checks = 0, errs = 0;
   int se0_rises = 0;

   always #2  ref_c    = ~ref_c;
   always #6  se_in[0] = ~se_in[0];
   always #10 se_in[1] = ~se_in[1];
   always #5  d1       = ~d1;
   assign dt_in = {d1, ~ref_c};
   assign dc_in = {~d1, ref_c};

   pwrdn_clk_seq #(.N_SE(2), .N_DIFF(2), .SYNC_STAGES(2)) u_dut (
      .rst_ni(rst_n), .ref_c_i(ref_c), .pd_i(pd), .lock_i(lock), .drv_mode_i(mode),
      .se_clk_i(se_in), .dt_i(dt_in), .dc_i(dc_in),
      .se_clk_o(se_o), .dt_o(dt_o), .dt_oe_o(dt_oe), .dc_o(dc_o), .dc_oe_o(dc_oe),
      .vco_off_o(vco_off), .osc_off_o(osc_off), .pd_done_o(done)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge ref_c);
      #1;
   endtask

   task automatic sample();
      @(posedge ref_c);
      #0.5;
   endtask

   // R2: every high pulse on a single-ended output has full width
   for (genvar g = 0; g < 2; g++) begin : g_mon
      realtime t_rise = -1.0;
      always @(posedge se_o[g]) t_rise = $realtime;
      always @(negedge se_o[g]) if (t_rise >= 0.0) begin
         realtime w, e;
         w = $realtime - t_rise;
         e = (g == 0) ? 6.0 : 10.0;
         checks++;
         if (w < e - 0.01 || w > e + 0.01) begin
            errs++;
            $display("FAIL R2: pulse width on se%0d actual=%0t expected=%0t", g, w, e);
         end
      end
   end

   always @(posedge se_o[0]) se0_rises++;

   // R6: shutdown requests only after everything is parked
   always @(posedge vco_off) begin
      #0.1;
      chk("R6 se low at vco_off", {30'd0, se_o}, 32'd0);
      chk("R6 dc_oe low at vco_off", {30'd0, dc_oe}, 32'd0);
   end
   always @(posedge osc_off) begin
      #0.1;
      chk("R6 vco_off before osc_off", {31'd0, vco_off}, 32'd1);
   end

   task automatic wait_done();
      for (int n = 0; n < 300 && !done; n++) @(posedge ref_c);
      #0.5;
      chk("R6 pd_done reached", {31'd0, done}, 32'd1);
   endtask

   task automatic t_reset();
      sample();
      chk("R9 vco_off in reset", {31'd0, vco_off}, 32'd0);
      chk("R9 se passes in reset", {30'd0, se_o}, {30'd0, se_in});
      rst_n = 1'b1;
      step(10);
      sample();
      chk("R9 osc_off/done idle", {30'd0, osc_off, done}, 32'd0);
      chk("R9 se passes", {30'd0, se_o}, {30'd0, se_in});
      chk("R9 dt passes", {30'd0, dt_o}, {30'd0, dt_in});
      chk("R9 enables", {28'd0, dt_oe, dc_oe}, 32'hF);
   endtask

   task automatic t_glitch();
      int r0;
      @(posedge ref_c); #1;
      pd = 1'b1; #6; pd = 1'b0;
      r0 = se0_rises;
      step(30);
      sample();
      chk("R1 short pulse: no done", {31'd0, done}, 32'd0);
      chk("R1 short pulse: enables", {28'd0, dt_oe, dc_oe}, 32'hF);
      chk("R1 short pulse: still toggling", {31'd0, (se0_rises > r0)}, 32'd1);
   endtask

   task automatic t_entry(input logic [1:0] m);
      step(1);
      mode = m; pd = 1'b1; lock = 1'b0;
      wait_done();
      chk("R6 vco/osc off", {30'd0, vco_off, osc_off}, 32'd3);
      chk("R2 se held low", {30'd0, se_o}, 32'd0);
      for (int j = 0; j < 2; j++) begin
         if (!m[j]) begin
            chk("R3 mode0 true driven high", {30'd0, dt_o[j], dt_oe[j]}, 32'd3);
            chk("R3 mode0 comp floating", {31'd0, dc_oe[j]}, 32'd0);
         end else begin
            chk("R4 mode1 both floating", {30'd0, dt_oe[j], dc_oe[j]}, 32'd0);
         end
      end
   endtask

   task automatic t_mode_change_and_quiet(input logic [1:0] m);
      logic [9:0] snap;
      mode = ~m;
      step(5);
      sample();
      chk("R5 mode change ignored", {28'd0, dt_oe, dc_oe},
          {28'd0, ~m, 2'b00});
      snap = {se_o, dt_o, dt_oe, dc_o, dc_oe};
      for (int k = 0; k < 40; k++) begin
         #2.5;
         chk("R10 outputs frozen", {22'd0, se_o, dt_o, dt_oe, dc_o, dc_oe}, {22'd0, snap});
      end
   endtask

   task automatic t_exit(input logic [1:0] m);
      int r0;
      step(1);
      pd = 1'b0;
      #0.5;
      chk("R7 requests cleared at once", {30'd0, vco_off, osc_off}, 32'd0);
      chk("R7 true legs driven high", {28'd0, dt_o, dt_oe}, 32'hF);
      chk("R7 comp legs still floating", {30'd0, dc_oe}, 32'd0);
      step(30);
      sample();
      chk("R8 parked until lock", {30'd0, se_o}, 32'd0);
      chk("R8 comp floating until lock", {30'd0, dc_oe}, 32'd0);
      lock = 1'b1;
      step(15);
      r0 = se0_rises;
      step(30);
      sample();
      chk("R8 resumed toggling", {31'd0, (se0_rises > r0)}, 32'd1);
      chk("R8 se passes input", {30'd0, se_o}, {30'd0, se_in});
      chk("R8 enables back", {28'd0, dt_oe, dc_oe}, 32'hF);
      chk("R8 done cleared", {31'd0, done}, 32'd0);
      mode = m;
   endtask

   initial begin
      #500us;
      checks++; errs++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
   end

   initial begin
      t_reset();
      t_glitch();
      t_entry(2'b10);
      t_mode_change_and_quiet(2'b10);
      t_exit(2'b10);
      t_entry(2'b01);
      t_mode_change_and_quiet(2'b01);
      t_exit(2'b01);
      summary();
   end
endmodule